// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides which of five interrupt sources the core should service next. One source cannot be blocked by software and always wins. Three sources are maskable and each carries a fixed restart address. The fifth is a general maskable request whose vector is supplied from outside the block. The controller holds a global interrupt enable and three per-source mask bits. Software drives them through command strobes, and a status word reports them back.

The core raises an instruction-boundary strobe when it could branch to a handler. In any cycle where that strobe is high and some source is eligible, the controller accepts the winner. It does four things in that cycle: it raises a take strobe, presents the winner's vector, acknowledges the general request if that source won, and clears the global enable. Nothing else is accepted until software enables interrupts again.

The high-priority maskable source is captured on its rising edge and held until it is serviced or cleared by software. The middle and low maskable sources follow their input level. The unmaskable source needs a fresh rising edge before each acceptance, and its input must still be high when it is taken.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three mask bits are 1, the held edge flags are clear, and `status` reads 7'h07 with all source inputs low. `irq_pending`, `irq_take` and `gen_ack` are 0.
- R2: The unmaskable source wins over every other source and presents vector 16'h0024. This holds even with the global enable at 0 and every mask bit at 1.
- R3: The unmaskable source is pending only while `nmi_in` is high and a rising edge of `nmi_in` has been registered since its last acceptance. Holding the input high after an acceptance does not make it pending again. A later low-then-high transition does.
- R4: Below the unmaskable source the fixed order is high, then middle, then low, then the general request. Their vectors are 16'h003C, 16'h0034, 16'h002C and `gen_vec_in`. With nothing pending, `irq_vector` is 0.
- R5: While the global enable is 0, none of the four maskable sources makes `irq_pending` high.
- R6: A mask bit of 1 blocks its source. `mask_wdata` bit 2 controls the high source, bit 1 the middle and bit 0 the low. The mask bits load only when `mask_wr` and `mask_upd` are both high. `mask_wr` without `mask_upd` leaves them unchanged.
- R7: A rising edge on `vhi_in` sets a held flag even while the source is masked, and the flag stays set after the input falls. The flag clears when the high source is accepted, or when `mask_wr` and `hi_clr` are both high. An edge in the same cycle as a clear keeps the flag set.
- R8: The middle and low sources are level-sensitive. Dropping the input removes the request with no memory of it.
- R9: `irq_take` is high exactly when `insn_boundary` and `irq_pending` are both high. An acceptance clears the global enable at the next clock edge and overrides `en_set` in the same cycle. Otherwise `en_set` sets the enable and `en_clr` clears it.
- R10: `gen_ack` is high only in a cycle where `irq_take` is high and the general request is the winner.
- R11: `status` reads {held high flag, `vmid_in`, `vlo_in`, global enable, mask[2:0]}, from bit 6 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Unmaskable request |
| vhi_in | input | 1 | High maskable request, rising-edge captured |
| vmid_in | input | 1 | Middle maskable request, level |
| vlo_in | input | 1 | Low maskable request, level |
| gen_req_in | input | 1 | General maskable request, level |
| gen_vec_in | input | VW | Vector used when the general request wins |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| en_set | input | 1 | Set the global enable |
| en_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Mask command strobe |
| mask_upd | input | 1 | Qualifier: load mask bits on `mask_wr` |
| hi_clr | input | 1 | Qualifier: clear the held high flag on `mask_wr` |
| mask_wdata | input | 3 | New mask bits {high, middle, low} |
| irq_pending | output | 1 | Some source is eligible |
| irq_take | output | 1 | Acceptance in this cycle |
| irq_vector | output | VW | Vector of the current winner |
| gen_ack | output | 1 | General request accepted |
| status | output | 7 | Readback of pending, enable and mask state |

## Verification
Two states are hard to reach from the ports. The first is an unmaskable input held high across its own acceptance. The bench takes the source and keeps `nmi_in` high over several cycles to show it stays quiet, then drops and raises the input to re-arm it. The second is acceptance in the same cycle as `en_set`. The bench reaches it by strobing both together while only the general request is live, then checking that the enable ends up cleared. The held high flag is driven while masked, cleared by software, and cleared again by service. Each of these is done so that readback alone shows whether the flag changed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int IX_TRAP = 0;
  localparam int IX_HI   = 1;
  localparam int IX_MID  = 2;
  localparam int IX_LO   = 3;
  localparam int IX_GEN  = 4;

  // lowest set bit wins: index 0 is the highest priority
  function automatic logic [NSRC-1:0] first_set(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic clr,
  output logic held,
  output logic rise
);
  logic prev_q;

  assign rise = level_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held   <= 1'b0;
    end else begin
      prev_q <= level_in;
      if (rise)     held <= 1'b1;
      else if (clr) held <= 1'b0;
    end
  end

  // R7 / R3: an edge always leaves the flag set
  a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> held);
  // R7 / R3: a clear with no new edge drops the flag
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !held);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VW-1:0] VEC_HI   = 16'h003C,
  parameter logic [VW-1:0] VEC_MID  = 16'h0034,
  parameter logic [VW-1:0] VEC_LO   = 16'h002C
) (
  input  logic [NSRC-1:0] elig,
  input  logic [VW-1:0]   ext_vec,
  output logic [NSRC-1:0] grant,
  output logic            any,
  output logic [VW-1:0]   vector
);
  logic [VW-1:0] vtab [NSRC];

  assign vtab[IX_TRAP] = VEC_TRAP;
  assign vtab[IX_HI]   = VEC_HI;
  assign vtab[IX_MID]  = VEC_MID;
  assign vtab[IX_LO]   = VEC_LO;
  assign vtab[IX_GEN]  = ext_vec;

  assign grant = first_set(elig);
  assign any   = |elig;

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vector = vector | vtab[i];
  end

  always_comb begin
    a_r4_onehot: assert ($onehot0(grant));
    a_r4_gen_last: assert (!(grant[IX_GEN] && (|elig[IX_LO:IX_TRAP])));
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VW-1:0] VEC_HI   = 16'h003C,
  parameter logic [VW-1:0] VEC_MID  = 16'h0034,
  parameter logic [VW-1:0] VEC_LO   = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_in,
  input  logic          vhi_in,
  input  logic          vmid_in,
  input  logic          vlo_in,
  input  logic          gen_req_in,
  input  logic [VW-1:0] gen_vec_in,
  input  logic          insn_boundary,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          mask_wr,
  input  logic          mask_upd,
  input  logic          hi_clr,
  input  logic [2:0]    mask_wdata,
  output logic          irq_pending,
  output logic          irq_take,
  output logic [VW-1:0] irq_vector,
  output logic          gen_ack,
  output logic [6:0]    status
);
  localparam int NMASK = 3;

  logic             gie_q;
  logic [NMASK-1:0] mask_q;
  logic             nmi_armed, nmi_rise;
  logic             hi_held, hi_rise;
  logic [NMASK-1:0] raw_m, elig_m;
  logic [NSRC-1:0]  elig, grant;
  logic             any;
  logic             take_trap, take_hi, sw_hi_clr;

  assign take_trap = irq_take & grant[IX_TRAP];
  assign take_hi   = irq_take & grant[IX_HI];
  assign sw_hi_clr = mask_wr & hi_clr;

  irq_edge_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .level_in(nmi_in), .clr(take_trap),
    .held(nmi_armed), .rise(nmi_rise)
  );

  irq_edge_latch u_hi (
    .clk(clk), .rst_n(rst_n), .level_in(vhi_in), .clr(take_hi | sw_hi_clr),
    .held(hi_held), .rise(hi_rise)
  );

  // mask bit order: 2 high, 1 middle, 0 low
  assign raw_m = {hi_held, vmid_in, vlo_in};

  for (genvar i = 0; i < NMASK; i++) begin : g_mask
    assign elig_m[i] = raw_m[i] & ~mask_q[i] & gie_q;
  end

  assign elig = {gen_req_in & gie_q, elig_m[0], elig_m[1], elig_m[2],
                 nmi_in & nmi_armed};

  irq_arbiter #(
    .VW(VW), .VEC_TRAP(VEC_TRAP), .VEC_HI(VEC_HI),
    .VEC_MID(VEC_MID), .VEC_LO(VEC_LO)
  ) u_arb (
    .elig(elig), .ext_vec(gen_vec_in), .grant(grant),
    .any(any), .vector(irq_vector)
  );

  assign irq_pending = any;
  assign irq_take    = insn_boundary & any;
  assign gen_ack     = irq_take & grant[IX_GEN];
  assign status      = {raw_m, gie_q, mask_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (irq_take)    gie_q <= 1'b0;
      else if (en_set) gie_q <= 1'b1;
      else if (en_clr) gie_q <= 1'b0;
      if (mask_wr && mask_upd) mask_q <= mask_wdata;
    end
  end

  a_r9_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !gie_q);
  a_r9_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |-> !irq_take);
  a_r2_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && nmi_armed) |-> (irq_pending && irq_vector == VEC_TRAP));
  a_r3_trap_once: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && !nmi_rise) |=> !nmi_armed);
  a_r5_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !(nmi_in && nmi_armed)) |-> !irq_pending);
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(mask_wr && mask_upd) |=> $stable(mask_q));
  a_r10_ack_gen: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |-> (irq_take && gen_req_in && gie_q));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int VW = 16;
  localparam logic [15:0] EXTV = 16'h00C8;

  logic clk = 1'b0;
  logic rst_n;
  logic nmi_in, vhi_in, vmid_in, vlo_in, gen_req_in;
  logic insn_boundary, en_set, en_clr, mask_wr, mask_upd, hi_clr;
  logic [2:0] mask_wdata;
  logic irq_pending, irq_take, gen_ack;
  logic [VW-1:0] irq_vector;
  logic [6:0] status;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .vhi_in(vhi_in),
    .vmid_in(vmid_in), .vlo_in(vlo_in), .gen_req_in(gen_req_in),
    .gen_vec_in(EXTV), .insn_boundary(insn_boundary), .en_set(en_set),
    .en_clr(en_clr), .mask_wr(mask_wr), .mask_upd(mask_upd), .hi_clr(hi_clr),
    .mask_wdata(mask_wdata), .irq_pending(irq_pending), .irq_take(irq_take),
    .irq_vector(irq_vector), .gen_ack(gen_ack), .status(status)
  );

  // fields: [23:21] mask, [20] hi edge, [19] mid, [18] lo, [17] gen, [16] pending, [15:0] vector
  localparam logic [23:0] TBL [8] = '{
    {3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h003C},
    {3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0034},
    {3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h002C},
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h00C8},
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0034},
    {3'b011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h00C8},
    {3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
    {3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h002C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    nmi_in = 0; vhi_in = 0; vmid_in = 0; vlo_in = 0; gen_req_in = 0;
    insn_boundary = 0; en_set = 0; en_clr = 0; mask_wr = 0; mask_upd = 0;
    hi_clr = 0; mask_wdata = 3'b000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic write_mask(input logic [2:0] m);
    @(negedge clk);
    mask_wr = 1; mask_upd = 1; mask_wdata = m;
    @(negedge clk);
    mask_wr = 0; mask_upd = 0;
  endtask

  task automatic pulse_en();
    @(negedge clk);
    en_set = 1;
    @(negedge clk);
    en_set = 0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    @(negedge clk); #2;
    chk("R1 status", 32'(status), 32'h07);
    chk("R1 pending", 32'(irq_pending), 0);
    chk("R1 take/ack", 32'({irq_take, gen_ack}), 0);

    // table walk: global enable on, no boundary
    pulse_en();
    foreach (TBL[k]) begin
      @(negedge clk);
      mask_wr = 1; mask_upd = 1; hi_clr = 1; mask_wdata = TBL[k][23:21];
      vhi_in = TBL[k][20]; vmid_in = TBL[k][19]; vlo_in = TBL[k][18];
      gen_req_in = TBL[k][17];
      @(negedge clk);
      mask_wr = 0; mask_upd = 0; hi_clr = 0; vhi_in = 0;
      #2;
      chk("R4 R6 R7 table pending", 32'(irq_pending), 32'(TBL[k][16]));
      chk("R4 table vector", 32'(irq_vector), 32'(TBL[k][15:0]));
    end

    // R5: global enable off blocks maskable sources
    do_reset();
    write_mask(3'b000);
    @(negedge clk);
    vmid_in = 1; gen_req_in = 1; #2;
    chk("R5 blocked by enable", 32'(irq_pending), 0);
    chk("R11 status layout", 32'(status), 32'h20);
    pulse_en();
    #2;
    chk("R4 middle over general", 32'(irq_vector), 32'h0034);
    @(negedge clk);
    insn_boundary = 1; #2;
    chk("R9 take at boundary", 32'(irq_take), 1);
    chk("R10 no ack when middle wins", 32'(gen_ack), 0);
    @(negedge clk);
    insn_boundary = 0; #2;
    chk("R9 enable cleared by take", 32'(irq_pending), 0);
    chk("R11 enable bit cleared", 32'(status), 32'h20);

    // R9/R10: take together with en_set
    @(negedge clk);
    vmid_in = 0; en_set = 1;
    @(negedge clk);
    en_set = 1; insn_boundary = 1; #2;
    chk("R10 ack general", 32'({irq_take, gen_ack}), 32'b11);
    chk("R4 external vector", 32'(irq_vector), 32'(EXTV));
    @(negedge clk);
    en_set = 0; insn_boundary = 0; gen_req_in = 0; #2;
    chk("R9 take beats en_set", 32'(status[3]), 0);

    // R8 level sources
    pulse_en();
    @(negedge clk);
    vlo_in = 1; #2;
    chk("R8 low pending", 32'(irq_vector), 32'h002C);
    @(negedge clk);
    vlo_in = 0; #2;
    chk("R8 low dropped", 32'(irq_pending), 0);

    // R6 qualifier
    @(negedge clk);
    vlo_in = 1; mask_wr = 1; mask_upd = 0; mask_wdata = 3'b111;
    @(negedge clk);
    mask_wr = 0; #2;
    chk("R6 no qualifier keeps masks", 32'(status[2:0]), 0);
    chk("R6 low still pending", 32'(irq_pending), 1);
    write_mask(3'b111);
    #2;
    chk("R6 masked low", 32'(irq_pending), 0);
    @(negedge clk);
    vlo_in = 0;

    // R7 held high flag
    @(negedge clk);
    vhi_in = 1;
    @(negedge clk);
    vhi_in = 0; #2;
    chk("R7 flag set while masked", 32'(status[6]), 1);
    chk("R7 masked not pending", 32'(irq_pending), 0);
    write_mask(3'b011);
    #2;
    chk("R7 unmasked vector", 32'(irq_vector), 32'h003C);
    @(negedge clk);
    mask_wr = 1; hi_clr = 1;
    @(negedge clk);
    mask_wr = 0; hi_clr = 0; #2;
    chk("R7 software clear", 32'({status[6], irq_pending}), 0);
    @(negedge clk);
    vhi_in = 1;
    @(negedge clk);
    vhi_in = 0; insn_boundary = 1; #2;
    chk("R7 take high", 32'(irq_take), 1);
    @(negedge clk);
    insn_boundary = 0; #2;
    chk("R7 service clears flag", 32'(status[6]), 0);

    // R2/R3 unmaskable source, enable off and masks set
    write_mask(3'b111);
    @(negedge clk);
    nmi_in = 1; #2;
    chk("R3 not armed before edge", 32'(irq_pending), 0);
    @(negedge clk); #2;
    chk("R2 trap pending", 32'(irq_pending), 1);
    chk("R2 trap vector", 32'(irq_vector), 32'h0024);
    @(negedge clk);
    insn_boundary = 1; #2;
    chk("R2 trap taken", 32'(irq_take), 1);
    @(negedge clk);
    insn_boundary = 0;
    @(negedge clk); #2;
    chk("R3 held high stays quiet", 32'(irq_pending), 0);
    @(negedge clk);
    nmi_in = 0;
    @(negedge clk);
    nmi_in = 1;
    write_mask(3'b000);
    pulse_en();
    @(negedge clk);
    vhi_in = 1; vlo_in = 1;
    @(negedge clk); #2;
    chk("R3 re-armed by new edge", 32'(irq_pending), 1);
    chk("R2 trap over high", 32'(irq_vector), 32'h0024);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule